// File: doc/BRIEF.md
# I2S to Simultaneous-Stereo DAC Formatter

This block takes a standard I2S stream and re-serializes every stereo frame for a multibit ladder DAC that has two data inputs. The left word leaves on one data pin and the right word on another, both clocked by one output bit clock. A latch-enable strobe follows the last bit of each word pair. A secondary clock, taken from the output word rate and divided by 1, 2 or 4, can reclock the DAC's element-matching circuit in step with the data.

Configuration pins choose the output coding: two's complement, or offset binary with the sign bit flipped. They also set a balanced mode, in which both lines carry one chosen channel and its saturated negation, so that a single dual-input DAC gives a differential output. A third option sends each captured pair eight times in back-to-back output frames, with no filtering. The whole block runs on one system clock. The I2S inputs are synchronized into that domain, and the output bit clock is divided down from it.

Top module: `ssd_top`

## Requirements
- R1: The input frame is 64 bit clocks long. Word select low marks the left slot. The MSB of each slot arrives on the second rising bit-clock edge after the word-select transition, and the first W bits of the slot are kept. With both modes off, DL carries the left word and DR the right word of the same frame.
- R2: Words shift out MSB first. Outputs change only right after a falling edge of obck_o and hold steady while it is high. Each output frame is OFRAME bit periods long. The W data bits fill slots 0 to W-1, and le_o is high for exactly slot W, with both data lines low during that slot.
- R3: A pair is released only after the left and then the right slot of one input frame are both complete, so DL and DR always come from the same frame.
- R4: With offset_bin_i high, bit W-1 (the MSB) of the word on each line is inverted relative to the two's-complement value.
- R5: With balanced_i high, DL carries the channel chosen by bal_src_i (0 = left, 1 = right) and DR carries its two's-complement negation (inverted, plus one).
- R6: In balanced mode, negating the most negative code (only bit W-1 set) saturates to the most positive code (all bits except bit W-1 set).
- R7: With balanced and offset-binary both on, the negation is done in two's complement first, and then the MSB of each line is inverted.
- R8: With rep8_i high, each pair is sent in exactly eight consecutive output frames. With rep8_i low, each pair is sent exactly once.
- R9: With dem_div_i = 0, dem_o follows le_o. With 1, dem_o toggles at the start of every latch pulse. With 2, it toggles at every second latch pulse.
- R10: After reset, dl_o, dr_o and le_o stay low until the first complete input frame has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| i2s_bck_i | input | 1 | I2S bit clock |
| i2s_ws_i | input | 1 | I2S word select, low for left |
| i2s_sd_i | input | 1 | I2S serial data |
| offset_bin_i | input | 1 | Offset-binary output coding |
| balanced_i | input | 1 | Balanced mode (channel and its negation) |
| bal_src_i | input | 1 | Balanced source: 0 left, 1 right |
| rep8_i | input | 1 | Send each pair eight times |
| dem_div_i | input | 2 | Element-matching clock divider: 0 /1, 1 /2, 2 /4 |
| obck_o | output | 1 | Output bit clock |
| le_o | output | 1 | Latch-enable strobe |
| dl_o | output | 1 | Left or primary data line |
| dr_o | output | 1 | Right or negated data line |
| dem_o | output | 1 | Divided clock for element matching |

## Verification
A pair becomes ready a few system clocks after the rising bit-clock edge that carries the last kept right-slot bit: the synchronizer depth plus one register. The serializer then picks the pair up at the next falling edge of obck_o, and the latch pulse follows W output bit periods later. No check depends on a fixed cycle count. The bench samples dl_o, dr_o, le_o and dem_o one half system clock after each rising obck_o edge and collects a word each time le_o is seen. After each group of frames it waits a drain window longer than eight output frames, then compares the collected words and their count against values computed from the requirements.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  typedef enum logic [1:0] {
    DEM_DIV1 = 2'd0,
    DEM_DIV2 = 2'd1,
    DEM_DIV4 = 2'd2
  } dem_div_e;
endpackage

// File: rtl/ssd_i2s_rx.sv
module ssd_i2s_rx #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bck_i,
  input  logic         ws_i,
  input  logic         sd_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         pair_o
);
  localparam int CW = $clog2(W + 1);

  logic [SYNC-1:0] bck_s, ws_s, sd_s;
  logic            bck_q, ws_prev, chan, lvalid;
  logic [CW-1:0]   cnt;
  logic [W-1:0]    sreg, word_nx;
  logic            rise, ws_cur, sd_cur;

  assign rise    = bck_s[SYNC-1] & ~bck_q;
  assign ws_cur  = ws_s[SYNC-1];
  assign sd_cur  = sd_s[SYNC-1];
  assign word_nx = {sreg[W-2:0], sd_cur};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_s <= '0;
      ws_s  <= '1;
      sd_s  <= '0;
    end else begin
      bck_s <= {bck_s[SYNC-2:0], bck_i};
      ws_s  <= {ws_s[SYNC-2:0], ws_i};
      sd_s  <= {sd_s[SYNC-2:0], sd_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_q   <= 1'b0;
      ws_prev <= 1'b1;
      chan    <= 1'b0;
      cnt     <= CW'(W);
      sreg    <= '0;
      left_o  <= '0;
      right_o <= '0;
      lvalid  <= 1'b0;
      pair_o  <= 1'b0;
    end else begin
      pair_o <= 1'b0;
      bck_q  <= bck_s[SYNC-1];
      if (rise) begin
        ws_prev <= ws_cur;
        if (ws_cur != ws_prev) begin
          // slot boundary: this edge still carries the previous slot's tail
          cnt  <= '0;
          chan <= ws_cur;
        end else if (cnt < CW'(W)) begin
          sreg <= word_nx;
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) begin
            if (!chan) begin
              left_o <= word_nx;
              lvalid <= 1'b1;
            end else if (lvalid) begin
              right_o <= word_nx;
              lvalid  <= 1'b0;
              pair_o  <= 1'b1;
            end
          end
        end
      end
    end
  end

  assert_pair_same_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> (!lvalid && $past(lvalid)));
endmodule

// File: rtl/ssd_fmt.sv
module ssd_fmt #(
  parameter int W = 16
) (
  input  logic [W-1:0] l_i,
  input  logic [W-1:0] r_i,
  input  logic         ob_i,
  input  logic         bal_i,
  input  logic         src_i,
  output logic [W-1:0] dl_o,
  output logic [W-1:0] dr_o
);
  localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_CODE = ~MIN_CODE;

  logic [W-1:0] base, neg, a, b, flip;

  always_comb begin
    base = src_i ? r_i : l_i;
    neg  = (base == MIN_CODE) ? MAX_CODE : (~base + W'(1));
    a    = bal_i ? base : l_i;
    b    = bal_i ? neg  : r_i;
    flip = ob_i ? MIN_CODE : '0;
    dl_o = a ^ flip;
    dr_o = b ^ flip;
  end
endmodule

// File: rtl/ssd_ser.sv
module ssd_ser
  import ssd_pkg::*;
#(
  parameter int W         = 16,
  parameter int OFRAME    = 24,
  parameter int OBCK_HALF = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] l_i,
  input  logic [W-1:0] r_i,
  input  logic         pair_i,
  input  logic [W-1:0] fl_i,
  input  logic [W-1:0] fr_i,
  input  logic         rep8_i,
  input  logic [1:0]   dem_div_i,
  output logic [W-1:0] hold_l_o,
  output logic [W-1:0] hold_r_o,
  output logic         obck_o,
  output logic         le_o,
  output logic         dl_o,
  output logic         dr_o,
  output logic         dem_o
);
  localparam int SW = $clog2(OFRAME);
  localparam int DW = (OBCK_HALF > 1) ? $clog2(OBCK_HALF) : 1;

  logic [DW-1:0] div_cnt;
  logic [SW-1:0] slot;
  logic [W-1:0]  sh_l, sh_r;
  logic [2:0]    rep;
  logic [1:0]    dem_cnt;
  logic          fall, pend, active, load, last_slot, seen;
  dem_div_e      dsel;

  assign fall      = obck_o && (div_cnt == DW'(OBCK_HALF - 1));
  assign last_slot = (slot == SW'(OFRAME - 1));
  assign dsel      = dem_div_e'(dem_div_i);

  always_comb begin
    load = 1'b0;
    if (fall) begin
      if (!active)        load = pend;
      else if (last_slot) load = pend | (rep8_i && rep != 3'd7);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
      obck_o  <= 1'b0;
    end else if (div_cnt == DW'(OBCK_HALF - 1)) begin
      div_cnt <= '0;
      obck_o  <= ~obck_o;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_o <= '0;
      hold_r_o <= '0;
      pend     <= 1'b0;
      active   <= 1'b0;
      slot     <= '0;
      sh_l     <= '0;
      sh_r     <= '0;
      rep      <= '0;
      dem_cnt  <= '0;
      seen     <= 1'b0;
    end else begin
      if (pair_i) begin
        hold_l_o <= l_i;
        hold_r_o <= r_i;
        seen     <= 1'b1;
      end
      pend <= pair_i | (pend & ~(load & pend));
      if (load) begin
        active <= 1'b1;
        slot   <= '0;
        sh_l   <= fl_i;
        sh_r   <= fr_i;
        rep    <= pend ? 3'd0 : rep + 3'd1;
      end else if (fall && active) begin
        if (last_slot) begin
          active <= 1'b0;
        end else begin
          slot <= slot + 1'b1;
          sh_l <= sh_l << 1;
          sh_r <= sh_r << 1;
          if (slot == SW'(W - 1)) dem_cnt <= dem_cnt + 2'd1;
        end
      end
    end
  end

  assign le_o = active && (slot == SW'(W));
  assign dl_o = active && (slot < SW'(W)) && sh_l[W-1];
  assign dr_o = active && (slot < SW'(W)) && sh_r[W-1];

  always_comb begin
    case (dsel)
      DEM_DIV1: dem_o = le_o;
      DEM_DIV2: dem_o = dem_cnt[0];
      default:  dem_o = dem_cnt[1];
    endcase
  end

  assert_stable_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obck_o && $past(obck_o)) |-> ($stable(dl_o) && $stable(dr_o) && $stable(le_o)));
  assert_le_after_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(le_o) |-> $fell(obck_o));
  assert_dem_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsel == DEM_DIV2 && $stable(dem_div_i) && $rose(le_o)) |-> (dem_o != $past(dem_o)));
  assert_reset_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen |-> (!le_o && !dl_o && !dr_o));
endmodule

// File: rtl/ssd_top.sv
module ssd_top #(
  parameter int W         = 16,
  parameter int OFRAME    = 24,
  parameter int OBCK_HALF = 2,
  parameter int SYNC      = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       i2s_bck_i,
  input  logic       i2s_ws_i,
  input  logic       i2s_sd_i,
  input  logic       offset_bin_i,
  input  logic       balanced_i,
  input  logic       bal_src_i,
  input  logic       rep8_i,
  input  logic [1:0] dem_div_i,
  output logic       obck_o,
  output logic       le_o,
  output logic       dl_o,
  output logic       dr_o,
  output logic       dem_o
);
  logic [W-1:0] rx_l, rx_r, hold_l, hold_r, f_l, f_r;
  logic         rx_pair;

  ssd_i2s_rx #(.W(W), .SYNC(SYNC)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bck_i(i2s_bck_i), .ws_i(i2s_ws_i), .sd_i(i2s_sd_i),
    .left_o(rx_l), .right_o(rx_r), .pair_o(rx_pair)
  );

  ssd_fmt #(.W(W)) u_fmt (
    .l_i(hold_l), .r_i(hold_r),
    .ob_i(offset_bin_i), .bal_i(balanced_i), .src_i(bal_src_i),
    .dl_o(f_l), .dr_o(f_r)
  );

  ssd_ser #(.W(W), .OFRAME(OFRAME), .OBCK_HALF(OBCK_HALF)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .l_i(rx_l), .r_i(rx_r), .pair_i(rx_pair),
    .fl_i(f_l), .fr_i(f_r),
    .rep8_i(rep8_i), .dem_div_i(dem_div_i),
    .hold_l_o(hold_l), .hold_r_o(hold_r),
    .obck_o(obck_o), .le_o(le_o), .dl_o(dl_o), .dr_o(dr_o), .dem_o(dem_o)
  );
endmodule

// File: tb/tb_ssd_top.sv
module tb_ssd_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int BCK_HALF   = 8;
  localparam int MAXCAP     = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bck = 1'b1, ws = 1'b1, sd = 1'b0;
  logic       ob = 1'b0, bal = 1'b0, src = 1'b0, rep = 1'b0;
  logic [1:0] dsel = 2'd0;
  logic       obck, le, dl, dr, dem;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] cap_l [MAXCAP];
  logic [W-1:0] cap_r [MAXCAP];
  logic         cap_d [MAXCAP];
  int           n_cap = 0;
  logic [W-1:0] acc_l = '0, acc_r = '0;
  logic         obck_q = 1'b0, le_q = 1'b0;
  int           activity = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssd_top #(.W(W), .OFRAME(24), .OBCK_HALF(2), .SYNC(2)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .i2s_bck_i(bck), .i2s_ws_i(ws), .i2s_sd_i(sd),
    .offset_bin_i(ob), .balanced_i(bal), .bal_src_i(src), .rep8_i(rep),
    .dem_div_i(dsel),
    .obck_o(obck), .le_o(le), .dl_o(dl), .dr_o(dr), .dem_o(dem)
  );

  // monitor: sample on rising output bit clock, half a system clock later
  always @(negedge clk) begin
    if (dl || dr || le) activity++;
    if (obck && !obck_q) begin
      if (le) begin
        checks++;
        if (le_q || dl || dr) begin
          errors++;
          $display("FAIL R2 latch slot: le_prev=%0b dl=%0b dr=%0b expected 0 0 0", le_q, dl, dr);
        end
        if (n_cap < MAXCAP) begin
          cap_l[n_cap] = acc_l;
          cap_r[n_cap] = acc_r;
          cap_d[n_cap] = dem;
          n_cap++;
        end
      end else begin
        acc_l = {acc_l[W-2:0], dl};
        acc_r = {acc_r[W-2:0], dr};
      end
      le_q = le;
    end
    obck_q = obck;
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [W-1:0] l, input logic [W-1:0] r);
    for (int i = 0; i < 64; i++) begin
      logic [W-1:0] ch;
      int k;
      ch  = (i < 32) ? l : r;
      k   = i % 32;
      bck = 1'b0;
      ws  = (i >= 32);
      sd  = (k >= 1 && k <= W) ? ch[W-k] : 1'b0;
      repeat (BCK_HALF) @(negedge clk);
      bck = 1'b1;
      repeat (BCK_HALF) @(negedge clk);
    end
  endtask

  function automatic logic [W-1:0] pick(input int f, input int c);
    case (f)
      0: return c ? 16'h7FFF : 16'h8000;
      1: return c ? 16'hFFFF : 16'h0000;
      2: return c ? 16'h8001 : 16'h0001;
      3: return c ? 16'h8000 : 16'h7FFF;
      default: return 16'(f * 16'h9E37 + c * 16'h5A5B + 16'h1234);
    endcase
  endfunction

  task automatic expect_pair(input logic [W-1:0] l, input logic [W-1:0] r,
                             output logic [W-1:0] el, output logic [W-1:0] er);
    logic [W-1:0] s;
    if (bal) begin
      s  = src ? r : l;
      el = s;
      er = (s == 16'h8000) ? 16'h7FFF : 16'(16'h0000 - s);
    end else begin
      el = l;
      er = r;
    end
    if (ob) begin
      el = el ^ 16'h8000;
      er = er ^ 16'h8000;
    end
  endtask

  task automatic phase(input string req, input int nf, input int seed);
    int start, per;
    logic [W-1:0] ls [16];
    logic [W-1:0] rs [16];
    start = n_cap;
    per   = rep ? 8 : 1;
    for (int f = 0; f < nf; f++) begin
      ls[f] = pick(f + seed, 0);
      rs[f] = pick(f + seed, 1);
      send_frame(ls[f], rs[f]);
    end
    repeat (1500) @(negedge clk);
    checks++;
    if (n_cap - start != nf * per) begin
      errors++;
      $display("FAIL R8 %s word count: actual %0d expected %0d", req, n_cap - start, nf * per);
    end
    for (int k = start; k < n_cap && k < start + nf * per; k++) begin
      logic [W-1:0] el, er;
      expect_pair(ls[(k - start) / per], rs[(k - start) / per], el, er);
      check({req, " DL"}, cap_l[k], el);
      check({req, " DR"}, cap_r[k], er);
      if (dsel == 2'd0) check("R9 div1", W'(cap_d[k]), W'(1));
      else if (dsel == 2'd1 && k > start) check("R9 div2", W'(cap_d[k]), W'(!cap_d[k-1]));
      else if (dsel == 2'd2 && k > start + 1) check("R9 div4", W'(cap_d[k]), W'(!cap_d[k-2]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R10 reset dl", W'(dl), W'(0));
    check("R10 reset le", W'(le), W'(0));
    rst_n = 1'b1;
    repeat (600) @(negedge clk);
    check("R10 idle before first frame", W'(activity), W'(0));

    phase("R1 R3 twos", 8, 0);
    dsel = 2'd1;
    ob = 1'b1;
    phase("R4 offset", 5, 3);
    ob = 1'b0; bal = 1'b1; src = 1'b0; dsel = 2'd2;
    phase("R5 R6 balanced left", 6, 0);
    src = 1'b1;
    phase("R5 R6 balanced right", 5, 0);
    ob = 1'b1; src = 1'b0;
    phase("R7 balanced offset", 5, 0);
    ob = 1'b0; bal = 1'b0; rep = 1'b1; dsel = 2'd1;
    phase("R8 repeat", 3, 4);
    rep = 1'b0; dsel = 2'd0;
    phase("R8 R2 single", 3, 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule